// File: doc/BRIEF.md
# UART Bus-Side Register File with Interrupt Prioritiser

This block is the processor-facing half of a classic byte-wide serial port. A CPU reaches eight byte registers through a 3-bit offset with separate read and write strobes. Bit 7 of the line control register acts as a bank-select bit for divisor access. When it is set, offsets 0 and 1 stop reaching the data and interrupt-enable registers and reach the two bytes of the baud divisor instead. The remaining registers have fixed offsets that the bank bit does not change: identification, line control, modem control, line status, modem status and scratch.

The serial shifters sit outside this block. The transmitter pulls the holding byte through a valid/ready stream. The receiver pushes each finished byte, and its error flags, as a one-cycle `rx_valid` pulse. That input has no ready: every byte is taken, and one that arrives while the previous byte is still unread replaces it and raises overrun. On the transmit side the stream waits for the transmitter. `tx_valid` and `tx_data` hold until `tx_ready`. The CPU side has no flow control, so a write to the holding register while it is still full replaces the byte that is waiting.

Four interrupt sources are each gated by an enable bit. They are combined into one interrupt line and into a two-bit code, ordered by a fixed priority. Read data is combinational on the current offset. Every side effect of a read or a write takes place at the clock edge that ends the strobe cycle.

Top module: `uart_regfile`

## Requirements
- R1: With `lcr[7]`=0, offset 0 reads the receive buffer and writes the transmit holding register, and offset 1 is the interrupt enable register. With `lcr[7]`=1, offset 0 is divisor low and offset 1 is divisor high. Both divisor bytes read back and drive `cfg_div` = {high, low}. A divisor write touches neither the holding register nor the enables.
- R2: The interrupt enable register stores write bits 0 to 3 and reads bits 4 to 7 as zero. The enable bits are: bit 0 received data, bit 1 holding empty, bit 2 line status, bit 3 modem status.
- R3: The identification register (offset 2) reads bit 0 as 0 when an enabled interrupt is pending and as 1 when none is pending. Bits 3 to 7 read as 0.
- R4: Identification bits 2:1 name the highest-priority enabled pending source. From highest to lowest: line status 11, received data 10, holding empty 01, modem status 00. So the register reads 0x06, 0x04, 0x02 or 0x00, and reads 0x01 when nothing is pending.
- R5: `irq` is high exactly when at least one enabled source is pending. A disabled source neither raises `irq` nor shows in the code.
- R6: Line status (offset 5) reads as {0, holding empty, holding empty, break, framing, parity, overrun, data ready}. Bits 1 to 4 are set by receive events and cleared by reading the register. A set in the same cycle as the read wins. The line status interrupt is pending while any of bits 1 to 4 is set.
- R7: `rx_valid` stores `rx_data` and sets data ready. `rx_err` bit 0 sets parity, bit 1 sets framing and bit 2 sets break. A byte that arrives while data ready is set, and is not being read in that cycle, sets overrun. Reading the receive buffer clears data ready, unless a byte arrives in the same cycle.
- R8: A holding-register write raises `tx_valid` in the next cycle with `tx_data` equal to the byte written. Both hold until a cycle with `tx_ready` high. A write while the register is full replaces the byte.
- R9: The holding-empty interrupt is raised when the transmitter takes the byte. It is also raised by a write that sets enable bit 1 from 0 while the holding register is empty. It is cleared by a read of the identification register that reports code 01, or by a holding-register write. The write takes precedence.
- R10: Modem status (offset 6) reads as {dcd, ri, dsr, cts} in bits 7:4. These levels are `modem_in[3:0]` registered once. Bits 0, 1 and 3 flag a change of cts, dsr and dcd. Bit 2 flags ri going from 1 to 0. The change bits clear on an MSR read, and a change in the same cycle wins. Any set change bit makes the modem interrupt pending.
- R11: Line control (offset 3, all 8 bits), modem control (offset 4, bits 0 to 4, upper bits read 0) and scratch (offset 7) read back what was written, whatever the value of `lcr[7]`. They drive `cfg_lcr` and `cfg_mcr`. Writes to offsets 2, 5 and 6 change nothing.
- R12: After reset every register reads 0, except identification, which reads 0x01, and line status, which reads 0x60. `irq` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | CPU read strobe; side effects at the edge |
| wr_en | input | 1 | CPU write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on addr |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Holding register full |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | Holding register byte |
| rx_valid | input | 1 | Received byte pulse |
| rx_data | input | 8 | Received byte |
| rx_err | input | 3 | {break, framing, parity} with rx_valid |
| modem_in | input | 4 | {dcd, ri, dsr, cts} levels |
| cfg_lcr | output | 8 | Line control to the shifters |
| cfg_mcr | output | 5 | Modem control outputs |
| cfg_div | output | 16 | Baud divisor |

## Verification
The bench keeps a register-level model and checks every read, along with `irq`, the stream outputs and the configuration outputs, in every cycle. Directed sequences come first. They stack line status, received data, holding-empty and modem events so that each priority pair is seen with both members pending. They also toggle each enable to show that masking removes a source from both `irq` and the code. Other directed cases put a set and a clear in the same cycle: a byte arriving during a buffer read, an error arriving during a status read, and a write during a transmitter take. Finally a seeded random mix of accesses, bank switches and events covers combinations that the directed cases miss.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned N_OFS    = 1 << ADDR_W;
  localparam int unsigned IER_W    = 4;
  localparam int unsigned MCR_W    = 5;
  localparam int unsigned ERR_W    = 3;
  localparam int unsigned LS_W     = 4;
  localparam int unsigned MODEM_W  = 4;
  localparam int unsigned DIV_W    = 2 * BYTE_W;
  localparam int unsigned BANK_BIT = 7;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IER  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IIR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LCR  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MCR  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSR  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSR  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_SCR  = 3'd7;

  // enable bit positions, also the source index into the pending vector
  localparam int unsigned EN_RX = 0;
  localparam int unsigned EN_TX = 1;
  localparam int unsigned EN_LS = 2;
  localparam int unsigned EN_MS = 3;

  typedef enum logic [1:0] {
    SRC_MODEM  = 2'b00,
    SRC_THRE   = 2'b01,
    SRC_RXDATA = 2'b10,
    SRC_LINE   = 2'b11
  } irq_src_e;

  typedef struct packed {
    logic rd_rbr;
    logic wr_thr;
    logic wr_dll;
    logic wr_dlm;
    logic wr_ier;
    logic rd_iir;
    logic wr_lcr;
    logic wr_mcr;
    logic rd_lsr;
    logic rd_msr;
    logic wr_scr;
  } strobe_t;
endpackage

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [ERR_W-1:0]  rx_err,
  input  logic              rd_rbr,
  input  logic              rd_lsr,
  output logic [BYTE_W-1:0] rbr,
  output logic              data_ready,
  output logic [LS_W-1:0]   ls_flags
);
  logic [LS_W-1:0] ls_set, ls_next;
  logic            overrun;

  always_comb begin
    overrun = rx_valid && data_ready && !rd_rbr;
    ls_set  = rx_valid ? {rx_err[2], rx_err[1], rx_err[0], overrun} : '0;
    ls_next = (rd_lsr ? '0 : ls_flags) | ls_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbr        <= '0;
      data_ready <= 1'b0;
      ls_flags   <= '0;
    end else begin
      if (rx_valid) rbr <= rx_data;
      if (rx_valid)    data_ready <= 1'b1;
      else if (rd_rbr) data_ready <= 1'b0;
      ls_flags <= ls_next;
    end
  end
endmodule

// File: rtl/uart_tx_holding.sv
module uart_tx_holding
  import uart_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_thr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_take
);
  assign tx_take = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (wr_thr) begin
        tx_valid <= 1'b1;
        tx_data  <= wdata;
      end else if (tx_take) begin
        tx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import uart_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MODEM_W-1:0] modem_in,
  input  logic               rd_msr,
  output logic [MODEM_W-1:0] level,
  output logic [MODEM_W-1:0] delta
);
  localparam int unsigned RI_IDX = 2;
  logic [MODEM_W-1:0] chg;

  // ri flags a falling edge only, the other lines flag any change
  for (genvar i = 0; i < MODEM_W; i++) begin : g_chg
    if (i == RI_IDX) begin : g_fall
      assign chg[i] = level[i] && !modem_in[i];
    end else begin : g_any
      assign chg[i] = level[i] ^ modem_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
      delta <= '0;
    end else begin
      level <= modem_in;
      delta <= (rd_msr ? '0 : delta) | chg;
    end
  end
endmodule

// File: rtl/uart_int_ctrl.sv
module uart_int_ctrl
  import uart_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IER_W-1:0]  ier,
  input  logic              ls_pend,
  input  logic              rx_pend,
  input  logic              ms_pend,
  input  logic              thr_load,
  input  logic              tx_take,
  input  logic              thr_empty,
  input  logic              thre_arm,
  input  logic              iir_rd,
  output logic              irq,
  output logic [BYTE_W-1:0] iir
);
  logic       thre_flag;
  logic [IER_W-1:0] raw, act;
  irq_src_e   code;
  logic       any;

  always_comb begin
    raw            = '0;
    raw[EN_RX]     = rx_pend;
    raw[EN_TX]     = thre_flag;
    raw[EN_LS]     = ls_pend;
    raw[EN_MS]     = ms_pend;
    act            = raw & ier;
    any            = |act;
    if (act[EN_LS])      code = SRC_LINE;
    else if (act[EN_RX]) code = SRC_RXDATA;
    else if (act[EN_TX]) code = SRC_THRE;
    else                 code = SRC_MODEM;
    iir = {{(BYTE_W-3){1'b0}}, code, !any};
  end

  assign irq = any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thre_flag <= 1'b0;
    end else begin
      if (thr_load)
        thre_flag <= 1'b0;
      else if (tx_take || (thre_arm && thr_empty))
        thre_flag <= 1'b1;
      else if (iir_rd && any && code == SRC_THRE)
        thre_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regs_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BYTE_W-1:0]         wdata,
  output logic [BYTE_W-1:0]         rdata,
  output logic                      irq,
  output logic                      tx_valid,
  input  logic                      tx_ready,
  output logic [BYTE_W-1:0]         tx_data,
  input  logic                      rx_valid,
  input  logic [BYTE_W-1:0]         rx_data,
  input  logic [ERR_W-1:0]          rx_err,
  input  logic [MODEM_W-1:0]        modem_in,
  output logic [BYTE_W-1:0]         cfg_lcr,
  output logic [MCR_W-1:0]          cfg_mcr,
  output logic [DIV_W-1:0]          cfg_div
);
  logic [N_OFS-1:0]  sel;
  strobe_t           stb;
  logic              bank;
  logic [IER_W-1:0]  ier_q;
  logic [BYTE_W-1:0] lcr_q, scr_q, dll_q, dlm_q;
  logic [MCR_W-1:0]  mcr_q;
  logic [BYTE_W-1:0] rbr, iir_val, lsr_val, msr_val;
  logic              data_ready, tx_take;
  logic [LS_W-1:0]   ls_flags;
  logic [MODEM_W-1:0] mlevel, mdelta;

  for (genvar i = 0; i < N_OFS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end

  assign bank = lcr_q[BANK_BIT];

  always_comb begin
    stb        = '0;
    stb.rd_rbr = rd_en && sel[OFS_DATA] && !bank;
    stb.wr_thr = wr_en && sel[OFS_DATA] && !bank;
    stb.wr_dll = wr_en && sel[OFS_DATA] &&  bank;
    stb.wr_dlm = wr_en && sel[OFS_IER]  &&  bank;
    stb.wr_ier = wr_en && sel[OFS_IER]  && !bank;
    stb.rd_iir = rd_en && sel[OFS_IIR];
    stb.wr_lcr = wr_en && sel[OFS_LCR];
    stb.wr_mcr = wr_en && sel[OFS_MCR];
    stb.rd_lsr = rd_en && sel[OFS_LSR];
    stb.rd_msr = rd_en && sel[OFS_MSR];
    stb.wr_scr = wr_en && sel[OFS_SCR];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      scr_q <= '0;
      dll_q <= '0;
      dlm_q <= '0;
    end else begin
      if (stb.wr_ier) ier_q <= wdata[IER_W-1:0];
      if (stb.wr_lcr) lcr_q <= wdata;
      if (stb.wr_mcr) mcr_q <= wdata[MCR_W-1:0];
      if (stb.wr_scr) scr_q <= wdata;
      if (stb.wr_dll) dll_q <= wdata;
      if (stb.wr_dlm) dlm_q <= wdata;
    end
  end

  uart_line_status u_ls (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_err     (rx_err),
    .rd_rbr     (stb.rd_rbr),
    .rd_lsr     (stb.rd_lsr),
    .rbr        (rbr),
    .data_ready (data_ready),
    .ls_flags   (ls_flags)
  );

  uart_tx_holding u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_thr   (stb.wr_thr),
    .wdata    (wdata),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_take  (tx_take)
  );

  uart_modem_status u_ms (
    .clk      (clk),
    .rst_n    (rst_n),
    .modem_in (modem_in),
    .rd_msr   (stb.rd_msr),
    .level    (mlevel),
    .delta    (mdelta)
  );

  uart_int_ctrl u_int (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier       (ier_q),
    .ls_pend   (|ls_flags),
    .rx_pend   (data_ready),
    .ms_pend   (|mdelta),
    .thr_load  (stb.wr_thr),
    .tx_take   (tx_take),
    .thr_empty (!tx_valid),
    .thre_arm  (stb.wr_ier && wdata[EN_TX] && !ier_q[EN_TX]),
    .iir_rd    (stb.rd_iir),
    .irq       (irq),
    .iir       (iir_val)
  );

  assign lsr_val = {1'b0, !tx_valid, !tx_valid, ls_flags, data_ready};
  assign msr_val = {mlevel, mdelta};

  always_comb begin
    unique case (addr)
      OFS_DATA: rdata = bank ? dll_q : rbr;
      OFS_IER:  rdata = bank ? dlm_q : BYTE_W'(ier_q);
      OFS_IIR:  rdata = iir_val;
      OFS_LCR:  rdata = lcr_q;
      OFS_MCR:  rdata = BYTE_W'(mcr_q);
      OFS_LSR:  rdata = lsr_val;
      OFS_MSR:  rdata = msr_val;
      default:  rdata = scr_q;
    endcase
  end

  assign cfg_lcr = lcr_q;
  assign cfg_mcr = mcr_q;
  assign cfg_div = {dlm_q, dll_q};
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk
  import uart_regs_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [BYTE_W-1:0]  rdata,
  input logic               irq,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [BYTE_W-1:0]  tx_data,
  input logic               rx_valid,
  input logic [MODEM_W-1:0] modem_in,
  input logic               bank,
  input logic [IER_W-1:0]   ier,
  input logic [BYTE_W-1:0]  lsr,
  input logic [BYTE_W-1:0]  msr
);
  logic thr_wr;
  assign thr_wr = wr_en && addr == OFS_DATA && !bank;

  assert_ier_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_IER && !bank) |-> rdata[7:4] == 4'b0);

  assert_iir_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_IIR) |-> rdata[7:3] == 5'b0);

  assert_line_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_IIR && ier[EN_LS] && |lsr[4:1]) |-> rdata[3:0] == 4'b0110);

  assert_irq_matches_iir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_IIR) |-> rdata[0] == !irq);

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == '0) |-> !irq);

  assert_lsr_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_LSR && !rx_valid) |=> lsr[4:1] == 4'b0);

  assert_rbr_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_DATA && !bank && !rx_valid) |=> !lsr[0]);

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !thr_wr) |=> (tx_valid && $stable(tx_data)));

  assert_msr_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_MSR && modem_in == msr[7:4]) |=> msr[3:0] == 4'b0);
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .rdata    (rdata),
  .irq      (irq),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .rx_valid (rx_valid),
  .modem_in (modem_in),
  .bank     (lcr_q[7]),
  .ier      (ier_q),
  .lsr      (lsr_val),
  .msr      (msr_val)
);

// File: tb/sim_uart_regfile.sv
`timescale 1ns/1ps
module sim_uart_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
  logic [2:0] addr = '0, rx_err = '0;
  logic [7:0] wdata = '0, rx_data = '0, rdata, tx_data, cfg_lcr;
  logic [3:0] modem_in = '0;
  logic [4:0] cfg_mcr;
  logic [15:0] cfg_div;
  logic irq, tx_valid;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  uart_regfile u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_err(rx_err), .modem_in(modem_in),
    .cfg_lcr(cfg_lcr), .cfg_mcr(cfg_mcr), .cfg_div(cfg_div)
  );

  // reference state, built from the requirements
  logic [3:0] m_ier = '0, m_err = '0, m_lvl = '0, m_dlt = '0;
  logic [7:0] m_lcr = '0, m_scr = '0, m_dll = '0, m_dlm = '0, m_rbr = '0, m_thr = '0;
  logic [4:0] m_mcr = '0;
  logic m_dr = 1'b0, m_full = 1'b0, m_thre = 1'b0;

  function automatic logic [3:0] m_act();
    return {|m_dlt & m_ier[3], |m_err & m_ier[2], m_thre & m_ier[1], m_dr & m_ier[0]};
  endfunction

  function automatic logic [7:0] exp_iir();
    logic [3:0] a = m_act();
    if (a[2]) return 8'h06;
    if (a[0]) return 8'h04;
    if (a[1]) return 8'h02;
    if (a[3]) return 8'h00;
    return 8'h01;
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_lcr[7] ? m_dll : m_rbr;
      3'd1: return m_lcr[7] ? m_dlm : {4'b0, m_ier};
      3'd2: return exp_iir();
      3'd3: return m_lcr;
      3'd4: return {3'b0, m_mcr};
      3'd5: return {1'b0, !m_full, !m_full, m_err, m_dr};
      3'd6: return {m_lvl, m_dlt};
      default: return m_scr;
    endcase
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic rd, input logic wr, input logic [2:0] a, input logic [7:0] wd,
                      input logic rxv, input logic [7:0] rxd, input logic [2:0] rxe,
                      input logic txr, input logic [3:0] mdm, input string tag);
    logic dl, rrbr, wthr, rlsr, rmsr, riir, wier, take;
    logic [7:0] iir_now;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wdata = wd; rx_valid = rxv; rx_data = rxd;
    rx_err = rxe; tx_ready = txr; modem_in = mdm;
    #1;
    if (rd) chk({8'h0, rdata}, {8'h0, exp_read(a)}, tag, "rdata");
    chk({15'h0, irq}, {15'h0, |m_act()}, tag, "irq");
    chk({15'h0, tx_valid}, {15'h0, m_full}, tag, "tx_valid");
    if (m_full) chk({8'h0, tx_data}, {8'h0, m_thr}, tag, "tx_data");
    chk({8'h0, cfg_lcr}, {8'h0, m_lcr}, tag, "cfg_lcr");
    chk({11'h0, cfg_mcr}, {11'h0, m_mcr}, tag, "cfg_mcr");
    chk(cfg_div, {m_dlm, m_dll}, tag, "cfg_div");
    dl = m_lcr[7];
    rrbr = rd && a == 3'd0 && !dl;
    wthr = wr && a == 3'd0 && !dl;
    wier = wr && a == 3'd1 && !dl;
    riir = rd && a == 3'd2;
    rlsr = rd && a == 3'd5;
    rmsr = rd && a == 3'd6;
    take = m_full && txr;
    iir_now = exp_iir();
    @(posedge clk);
    if (wthr) m_thre = 1'b0;
    else if (take || (wier && wd[1] && !m_ier[1] && !m_full)) m_thre = 1'b1;
    else if (riir && iir_now == 8'h02) m_thre = 1'b0;
    if (wthr) begin m_full = 1'b1; m_thr = wd; end
    else if (take) m_full = 1'b0;
    m_err = (rlsr ? 4'b0 : m_err) | (rxv ? {rxe, m_dr && !rrbr} : 4'b0);
    if (rxv) begin m_rbr = rxd; m_dr = 1'b1; end
    else if (rrbr) m_dr = 1'b0;
    m_dlt = (rmsr ? 4'b0 : m_dlt) |
            {mdm[3] ^ m_lvl[3], m_lvl[2] & ~mdm[2], mdm[1] ^ m_lvl[1], mdm[0] ^ m_lvl[0]};
    m_lvl = mdm;
    if (wier) m_ier = wd[3:0];
    if (wr && a == 3'd0 && dl) m_dll = wd;
    if (wr && a == 3'd1 && dl) m_dlm = wd;
    if (wr && a == 3'd3) m_lcr = wd;
    if (wr && a == 3'd4) m_mcr = wd[4:0];
    if (wr && a == 3'd7) m_scr = wd;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input string tag);
    step(1'b0, 1'b1, a, d, 1'b0, 8'h0, 3'b0, 1'b0, modem_in, tag);
  endtask
  task automatic rd_reg(input logic [2:0] a, input string tag);
    step(1'b1, 1'b0, a, 8'h0, 1'b0, 8'h0, 3'b0, 1'b0, modem_in, tag);
  endtask
  task automatic rx_byte(input logic [7:0] d, input logic [2:0] e, input string tag);
    step(1'b0, 1'b0, 3'd0, 8'h0, 1'b1, d, e, 1'b0, modem_in, tag);
  endtask
  task automatic idle(input logic txr, input logic [3:0] mdm, input string tag);
    step(1'b0, 1'b0, 3'd0, 8'h0, 1'b0, 8'h0, 3'b0, txr, mdm, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R12 reset values
    for (int a = 0; a < 8; a++) rd_reg(3'(a), "R12");
    // R11 fixed registers and ignored offsets
    wr_reg(3'd3, 8'h1B, "R11"); wr_reg(3'd4, 8'hFF, "R11"); wr_reg(3'd7, 8'hA5, "R11");
    wr_reg(3'd5, 8'hFF, "R11"); wr_reg(3'd6, 8'hFF, "R11"); wr_reg(3'd2, 8'hFF, "R11");
    for (int a = 2; a < 8; a++) rd_reg(3'(a), "R11");
    // R1 divisor bank
    wr_reg(3'd3, 8'h9B, "R1"); wr_reg(3'd0, 8'h34, "R1"); wr_reg(3'd1, 8'h12, "R1");
    rd_reg(3'd0, "R1"); rd_reg(3'd1, "R1"); rd_reg(3'd7, "R11"); rd_reg(3'd3, "R11");
    wr_reg(3'd3, 8'h1B, "R1"); rd_reg(3'd1, "R1"); rd_reg(3'd0, "R1");
    // R2 enables, R9 arming while empty, R3 pending bit
    wr_reg(3'd1, 8'hFF, "R2"); rd_reg(3'd1, "R2");
    rd_reg(3'd2, "R9"); rd_reg(3'd2, "R3");
    // R8 holding register stream
    wr_reg(3'd0, 8'h5A, "R8"); idle(1'b0, 4'h0, "R8"); idle(1'b0, 4'h0, "R8");
    wr_reg(3'd0, 8'h6B, "R8"); idle(1'b0, 4'h0, "R8"); idle(1'b1, 4'h0, "R8");
    rd_reg(3'd2, "R9"); wr_reg(3'd0, 8'h77, "R9"); rd_reg(3'd2, "R9");
    // R7 receive and overrun, R4/R6 priority and clearing
    rx_byte(8'h11, 3'b000, "R7"); rd_reg(3'd2, "R4");
    rx_byte(8'h22, 3'b000, "R7"); rd_reg(3'd2, "R4"); rd_reg(3'd5, "R6");
    rd_reg(3'd2, "R4"); rd_reg(3'd0, "R7"); rd_reg(3'd5, "R7");
    rx_byte(8'h33, 3'b111, "R6"); rd_reg(3'd5, "R6");
    step(1'b1, 1'b0, 3'd5, 8'h0, 1'b1, 8'h44, 3'b001, 1'b0, 4'h0, "R6");
    rd_reg(3'd5, "R6");
    step(1'b1, 1'b0, 3'd0, 8'h0, 1'b1, 8'h55, 3'b000, 1'b0, 4'h0, "R7");
    rd_reg(3'd5, "R7"); rd_reg(3'd0, "R7"); rd_reg(3'd2, "R4");
    // R10 modem lines
    idle(1'b1, 4'b0101, "R10"); rd_reg(3'd6, "R10"); rd_reg(3'd2, "R4"); rd_reg(3'd6, "R10");
    idle(1'b0, 4'b0001, "R10"); rd_reg(3'd6, "R10"); idle(1'b0, 4'b1001, "R10");
    rd_reg(3'd6, "R10"); rd_reg(3'd2, "R4");
    // R5 masking
    rx_byte(8'h66, 3'b010, "R5"); wr_reg(3'd1, 8'h00, "R5"); rd_reg(3'd2, "R5");
    wr_reg(3'd1, 8'h08, "R5"); rd_reg(3'd2, "R5"); wr_reg(3'd1, 8'h01, "R5"); rd_reg(3'd2, "R5");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = $urandom;
      logic [7:0]  d = 8'($urandom);
      logic [3:0]  m = modem_in;
      if (r[31:28] == 4'd0) m = 4'($urandom);
      step(r[0] & r[1], !r[0] & r[2], r[5:3], (r[5:3] == 3'd3) ? (d & 8'h9F) : d,
           r[8:6] == 3'd0, 8'($urandom), (r[11:9] == 3'd0) ? 3'($urandom) : 3'b0,
           r[12], m, "R4");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule